// File: doc/BRIEF.md
# Guest Interruptibility Blocking Tracker

This block keeps the four event-blocking conditions of a guest running under a monitor, advancing one retired instruction at a time. Two conditions are short shadows that cover exactly the one instruction after an interrupt-enable instruction or after a stack-segment load. The other two are long holds. Taking an SMI blocks further SMIs until a resume-from-SMM instruction retires. Taking an NMI or an SMI blocks NMIs until an interrupt-return or a resume-from-SMM retires.

The current conditions appear as a 4-bit state word. The monitor reads that word when it saves guest state on an exit. It writes it back through a load port on entry. From the word the block derives three blocked indications: one for external interrupts, one for NMI and one for SMI. Instruction decode and the actual delivery of events are handled by neighbouring logic.

The block has two state machines. The shadow machine has the states SH_CLEAR, SH_STI, SH_SS and SH_BOTH. An interrupt-enable retire moves it from SH_CLEAR or SH_SS to SH_STI, and from SH_STI or SH_BOTH to SH_CLEAR. A stack-segment retire moves it from SH_CLEAR or SH_STI to SH_SS, and from SH_SS or SH_BOTH to SH_CLEAR. Any other retire moves it to SH_CLEAR. A load moves it to any state, and SH_BOTH is reached only by a load. The hold machine has the states HD_OPEN, HD_SMI, HD_NMI and HD_BOTH. An SMI taken moves it to HD_BOTH. An NMI taken adds NMI blocking. An interrupt-return removes NMI blocking, which takes HD_BOTH to HD_SMI. A resume-from-SMM moves it to HD_OPEN. A load moves it to any state.

Top module: `intr_block_tracker`

## Requirements
- R1: Reset clears all four bits of the state word, and all three blocked outputs read 0.
- R2: When an instruction of class 1 (interrupt-enable) retires while bit 0 is clear, bit 0 is set on the next cycle.
- R3: When an instruction of class 2 (stack-segment load) retires while bit 1 is clear, bit 1 is set on the next cycle.
- R4: Bits 0 and 1 clear on any retire other than the one that sets them. A second consecutive retire of the same class clears the bit instead of extending the window. Classes 0 and 5 to 7 are "other".
- R5: An smi_taken pulse sets bit 2 and bit 3.
- R6: An nmi_taken pulse sets bit 3 and leaves bit 2 unchanged.
- R7: A retire of class 3 (interrupt-return) clears bit 3 and leaves bit 2 unchanged.
- R8: A retire of class 4 (resume-from-SMM) clears bit 2 and bit 3.
- R9: An event pulse in the same cycle as a retire that would clear the matching bit leaves that bit set.
- R10: blk_ext is bit 0 OR bit 1. blk_nmi is bit 1 OR bit 3. blk_smi is bit 2.
- R11: When ld_en is high, the state word equals ld_word on the next cycle. This overrides any retire or event pulse in the same cycle.
- R12: With no valid retire, no event pulse and no load, the state word holds its value. A class on retire_cls with retire_vld low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_cls | input | 3 | Class of the retiring instruction (0 other, 1 interrupt-enable, 2 stack-segment load, 3 interrupt-return, 4 resume-from-SMM) |
| smi_taken | input | 1 | An SMI is taken this cycle |
| nmi_taken | input | 1 | An NMI is taken this cycle |
| ld_en | input | 1 | Restore the state word from ld_word |
| ld_word | input | 4 | State word to restore |
| state_word | output | 4 | Bit 0 enable shadow, bit 1 stack shadow, bit 2 SMI hold, bit 3 NMI hold |
| blk_ext | output | 1 | External interrupts are blocked |
| blk_nmi | output | 1 | NMI is blocked |
| blk_smi | output | 1 | SMI is blocked |

## Verification
The embedded properties check the following on every cycle:
- the load override;
- that an idle cycle holds the state;
- that shadows set and clear on retires;
- the SMI and NMI set paths;
- the clear on resume-from-SMM.

Some behaviour shows only in the bench's scenarios:
- a second consecutive shadow-setting instruction does not extend the window;
- a shadow handed from one class to the other;
- an event racing a clearing retire;
- the derived blocked outputs across many words;
- a reset in the middle of a run.

// File: rtl/intr_blk_pkg.sv
package intr_blk_pkg;
    localparam int CLS_W  = 3;
    localparam int WORD_W = 4;

    typedef enum logic [CLS_W-1:0] {
        IC_OTHER = 3'd0,
        IC_STI   = 3'd1,
        IC_SSLD  = 3'd2,
        IC_IRET  = 3'd3,
        IC_RSM   = 3'd4
    } instr_cls_t;

    // bit0 enable shadow, bit1 stack shadow
    typedef enum logic [1:0] {
        SH_CLEAR = 2'b00,
        SH_STI   = 2'b01,
        SH_SS    = 2'b10,
        SH_BOTH  = 2'b11
    } sh_state_t;

    // bit0 SMI hold, bit1 NMI hold
    typedef enum logic [1:0] {
        HD_OPEN = 2'b00,
        HD_SMI  = 2'b01,
        HD_NMI  = 2'b10,
        HD_BOTH = 2'b11
    } hd_state_t;
endpackage

// File: rtl/blk_shadow_fsm.sv
module blk_shadow_fsm
    import intr_blk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_vld,
    input  logic [CLS_W-1:0] retire_cls,
    input  logic             ld_en,
    input  logic [1:0]       ld_bits,
    output logic [1:0]       sh_bits
);
    sh_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SH_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ld_en) begin
            state_d = sh_state_t'(ld_bits);
        end else if (retire_vld) begin
            unique case (state_q)
                SH_CLEAR: begin
                    if (retire_cls == IC_STI)       state_d = SH_STI;
                    else if (retire_cls == IC_SSLD) state_d = SH_SS;
                    else                            state_d = SH_CLEAR;
                end
                SH_STI: begin
                    if (retire_cls == IC_SSLD) state_d = SH_SS;
                    else                       state_d = SH_CLEAR;
                end
                SH_SS: begin
                    if (retire_cls == IC_STI) state_d = SH_STI;
                    else                      state_d = SH_CLEAR;
                end
                SH_BOTH: state_d = SH_CLEAR;
                default: state_d = SH_CLEAR;
            endcase
        end
    end

    always_comb sh_bits = state_q;

    // R2
    sti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && !ld_en && retire_cls == IC_STI && !sh_bits[0]) |=> sh_bits[0]);
    // R4
    shadow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && !ld_en && retire_cls != IC_STI && retire_cls != IC_SSLD) |=> sh_bits == 2'b00);
endmodule

// File: rtl/blk_hold_fsm.sv
module blk_hold_fsm
    import intr_blk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_vld,
    input  logic [CLS_W-1:0] retire_cls,
    input  logic             smi_taken,
    input  logic             nmi_taken,
    input  logic             ld_en,
    input  logic [1:0]       ld_bits,
    output logic [1:0]       hd_bits
);
    hd_state_t state_q, state_d, kept;
    logic      rsm_ret, iret_ret;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HD_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        rsm_ret  = retire_vld && (retire_cls == IC_RSM);
        iret_ret = retire_vld && (retire_cls == IC_IRET);
        unique case (state_q)
            HD_OPEN: kept = HD_OPEN;
            HD_SMI:  kept = rsm_ret ? HD_OPEN : HD_SMI;
            HD_NMI:  kept = (rsm_ret || iret_ret) ? HD_OPEN : HD_NMI;
            HD_BOTH: kept = rsm_ret ? HD_OPEN : (iret_ret ? HD_SMI : HD_BOTH);
            default: kept = HD_OPEN;
        endcase
        if (ld_en)          state_d = hd_state_t'(ld_bits);
        else if (smi_taken) state_d = HD_BOTH;
        else if (nmi_taken) state_d = hd_state_t'({1'b1, kept[0]});
        else                state_d = kept;
    end

    always_comb hd_bits = state_q;

    // R5
    smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_taken && !ld_en) |=> hd_bits == 2'b11);
    // R8
    rsm_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsm_ret && !smi_taken && !nmi_taken && !ld_en) |=> hd_bits == 2'b00);
endmodule

// File: rtl/intr_block_tracker.sv
module intr_block_tracker
    import intr_blk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_vld,
    input  logic [CLS_W-1:0]  retire_cls,
    input  logic              smi_taken,
    input  logic              nmi_taken,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    output logic [WORD_W-1:0] state_word,
    output logic              blk_ext,
    output logic              blk_nmi,
    output logic              blk_smi
);
    logic [1:0] sh_bits, hd_bits;

    blk_shadow_fsm u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_vld (retire_vld),
        .retire_cls (retire_cls),
        .ld_en      (ld_en),
        .ld_bits    (ld_word[1:0]),
        .sh_bits    (sh_bits)
    );

    blk_hold_fsm u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_vld (retire_vld),
        .retire_cls (retire_cls),
        .smi_taken  (smi_taken),
        .nmi_taken  (nmi_taken),
        .ld_en      (ld_en),
        .ld_bits    (ld_word[3:2]),
        .hd_bits    (hd_bits)
    );

    always_comb begin
        state_word = {hd_bits[1], hd_bits[0], sh_bits[1], sh_bits[0]};
        blk_ext    = sh_bits[0] | sh_bits[1];
        blk_nmi    = sh_bits[1] | hd_bits[1];
        blk_smi    = hd_bits[0];
    end

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> state_word == $past(ld_word));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_vld && !smi_taken && !nmi_taken && !ld_en) |=> $stable(state_word));
    // R6
    nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_taken && !ld_en) |=> state_word[3]);
endmodule

// File: tb/sim_intr_block_tracker.sv
module sim_intr_block_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retire_vld = 1'b0;
    logic [2:0] retire_cls = 3'd0;
    logic       smi_taken = 1'b0;
    logic       nmi_taken = 1'b0;
    logic       ld_en = 1'b0;
    logic [3:0] ld_word = 4'd0;
    logic [3:0] state_word;
    logic       blk_ext, blk_nmi, blk_smi;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    intr_block_tracker u0 (
        .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_cls(retire_cls),
        .smi_taken(smi_taken), .nmi_taken(nmi_taken), .ld_en(ld_en), .ld_word(ld_word),
        .state_word(state_word), .blk_ext(blk_ext), .blk_nmi(blk_nmi), .blk_smi(blk_smi)
    );

    // vector: {vld, cls[2:0], smi, nmi, ld, ldw[3:0], exp[3:0]}
    localparam int NV = 27;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0001},
        {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0001},
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0010},
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0001},
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0010},
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1000},
        {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 4'b1000},
        {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 4'h0, 4'b1100},
        {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0100},
        {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1100},
        {1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 4'h0, 4'b1100},
        {1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1100},
        {1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 4'hB, 4'b1011},
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 4'b1011},
        {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0, 4'b1000},
        {1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 4'h0, 4'b0000},
        {1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 4'h0, 4'b1010},
        {1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000},
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0010},
        {1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 4'h0, 4'b0000}
    };

    string tag [NV] = '{
        "R2", "R4", "R2", "R4", "R3", "R4", "R3", "R4", "R6", "R4", "R7", "R5",
        "R7", "R6", "R8", "R9", "R9", "R8", "R12", "R11", "R12", "R4", "R11",
        "R3", "R7", "R3", "R4"
    };

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // R10: derived outputs from the expected word
    task automatic check_outs(input logic [3:0] w);
        check({1'b0, blk_ext, blk_nmi, blk_smi},
              {1'b0, w[0] | w[1], w[1] | w[3], w[2]}, "R10");
    endtask

    task automatic drive(input logic [14:0] v);
        @(negedge clk);
        {retire_vld, retire_cls, smi_taken, nmi_taken, ld_en, ld_word} = v[14:4];
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(state_word, 4'b0000, "R1");
        check({1'b0, blk_ext, blk_nmi, blk_smi}, 4'b0000, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check(state_word, VEC[i][3:0], tag[i]);
            check_outs(VEC[i][3:0]);
        end

        // R11: load everything, then check the outputs
        drive({1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'hF, 4'h0});
        check(state_word, 4'hF, "R11");
        check_outs(4'hF);
        // R12: idle with a class present but not valid
        drive({1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0});
        check(state_word, 4'hF, "R12");
        // R4: a retire clears both shadows, even SH_BOTH
        drive({1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0});
        check(state_word, 4'b1100, "R4");

        // R1: reset in the middle of a run
        drive({1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'h7, 4'h0});
        @(negedge clk);
        ld_en = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(state_word, 4'b0000, "R1");
        check({1'b0, blk_ext, blk_nmi, blk_smi}, 4'b0000, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        drive(15'd0);
        check(state_word, 4'b0000, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule